// File: doc/BRIEF.md
# Mixed-Endian Load/Store Lane Steering

This block sits between a processor's load/store unit and a 32-bit little-endian memory data bus. It converts byte, halfword and word accesses into the address, byte strobes and lane-placed data that the bus expects. The address and data conversion depends on which of three data-endianness modes is in force:

- **Little-endian.**
- **Word-invariant big-endian.** This is the legacy mode. It keeps data lanes in place and renames the byte address of sub-word accesses.
- **Byte-invariant big-endian.** This mode keeps the address and reverses the byte order within the access size.

Two control bits select the mode: `cfg_u` picks the model and `cfg_b` requests the legacy big-endian form. A held status endian bit completes the selection. Software can write that bit, and it is reloaded from `cfg_ee` on reset and on every exception entry.

On the load side, the block remembers the lane, size, signedness and byte-order of the issued read. It then extracts and extends the data that returns on the bus. Instruction words use their own path, which never applies any data-endian conversion.

Top module: `endian_lane_steer`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mem_valid`, `align_fault`, `ld_valid` and `if_ivalid` are 0, and `e_bit` equals `cfg_ee`. With `cfg_u`=0 and `cfg_b`=0, accesses are little-endian.
- R2: A cycle with `exc_entry`=1 loads `e_bit` from `cfg_ee` at the next edge. This takes priority over a software write in the same cycle. Otherwise `e_wr_en`=1 loads `e_wr_val`. An access in the cycle of a change uses the old `e_bit`.
- R3: In little-endian mode, `mem_addr` equals `req_addr`, and write data is placed starting at lane `req_addr[1:0]` (lane n is bits 8n+7..8n). Request outputs appear one cycle after `req_valid`.
- R4: With `cfg_u`=0 and `cfg_b`=1 (word-invariant big-endian), the lane address bits change by access size:
  - a byte access uses address bits [1:0] XOR 3;
  - a halfword access inverts bit 1;
  - a word access keeps the address.

  Data bytes are not reordered, and `e_bit` has no effect.
- R5: With `cfg_u`=1 and `e_bit`=1 (byte-invariant big-endian), the address is unchanged. Halfword data has its two bytes swapped, word data has all four bytes reversed, and byte data is unchanged. This applies to both stores and loads.
- R6: With `cfg_u`=1 and `e_bit`=0, the block behaves as little-endian. With `cfg_u`=1, `cfg_b` has no effect.
- R7: `mem_strb` bit n enables lane n. A byte access sets one bit at its final lane, a halfword access sets two adjacent bits starting at the final lane, and a word access sets all four. `req_size` encodes 0 = byte, 1 = halfword, 2 = word.
- R8: A fault is raised in any of these cases:
  - a halfword request with `req_addr[0]`=1;
  - a word request with `req_addr[1:0]`≠0;
  - a request with `req_size`=3.

  On a fault, `align_fault` is 1 for one cycle and `mem_valid` stays 0.
- R9: One cycle after `mem_rvalid`, `ld_valid`=1 and `ld_data` holds the loaded value. That value is taken from the final lane of the last issued read, byte-ordered per R5, then sign-extended if `req_signed` was 1 at issue, else zero-extended. Byte lanes of `mem_wdata` that are not written are 0.
- R10: One cycle after `if_valid`, `if_ivalid`=1 and `if_instr` equals `if_rdata` unchanged, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_u | input | 1 | Selects the mixed-endian model (1) or the legacy model (0) |
| cfg_b | input | 1 | Legacy big-endian request, used when `cfg_u`=0 |
| cfg_ee | input | 1 | Endian value loaded into `e_bit` on reset and exception entry |
| exc_entry | input | 1 | Exception entry pulse |
| e_wr_en | input | 1 | Software write of the status endian bit |
| e_wr_val | input | 1 | Value for the software write |
| e_bit | output | 1 | Current status endian bit |
| req_valid | input | 1 | Data access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Sign-extend a sub-word load |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_valid | output | 1 | Bus request |
| mem_write | output | 1 | Bus request is a write |
| mem_addr | output | AW | Final byte address |
| mem_strb | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-placed write data |
| align_fault | output | 1 | Misaligned or invalid request |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned bus word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| if_valid | input | 1 | Instruction word returned |
| if_rdata | input | 32 | Fetched bus word |
| if_ivalid | output | 1 | Instruction valid |
| if_instr | output | 32 | Instruction word |

## Verification
The two operations that can coincide are an update of the status endian bit and a data access, and two updates of the endian bit can also coincide. The bench raises `exc_entry` and `e_wr_en` in the same cycle, with opposite values on `cfg_ee` and `e_wr_val`. It then reads back `e_bit` and expects the exception value. It also issues a halfword store in the very cycle that a software write turns on byte-invariant mode. It expects lane data in little-endian order for that store, and swapped bytes on the store that follows.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  localparam int LANES = 4;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int DW = 8 * LANES;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    MD_LE   = 2'd0,
    MD_WIBE = 2'd1,
    MD_BIBE = 2'd2
  } dmode_e;

  function automatic logic [DW-1:0] rev_bytes(input logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = d[8*(LANES-1-i) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/endian_mode_ctl.sv
module endian_mode_ctl
  import lane_steer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cfg_u,
  input  logic   cfg_b,
  input  logic   cfg_ee,
  input  logic   exc_entry,
  input  logic   e_wr_en,
  input  logic   e_wr_val,
  output logic   e_q,
  output dmode_e mode
);
  always_ff @(posedge clk) begin
    if (rst || exc_entry) e_q <= cfg_ee;
    else if (e_wr_en)     e_q <= e_wr_val;
  end

  always_comb begin
    if (!cfg_u) mode = cfg_b ? MD_WIBE : MD_LE;
    else        mode = e_q ? MD_BIBE : MD_LE;
  end

  // R2
  ee_reload_chk: assert property (@(posedge clk) disable iff (rst)
    exc_entry |=> (e_q == $past(cfg_ee)));

  // R2
  sw_write_chk: assert property (@(posedge clk) disable iff (rst)
    (e_wr_en && !exc_entry) |=> (e_q == $past(e_wr_val)));
endmodule

// File: rtl/access_map.sv
module access_map
  import lane_steer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dmode_e               mode,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 mem_valid,
  output logic                 mem_write,
  output logic [AW-1:0]        mem_addr,
  output logic [LANES-1:0]     mem_strb,
  output logic [DW-1:0]        mem_wdata,
  output logic                 align_fault,
  output logic                 rd_issue,
  output logic [LANE_BITS-1:0] rd_lane,
  output logic                 rd_swap
);
  logic                 misal;
  logic [LANE_BITS-1:0] lane;
  logic                 swap;
  logic [DW-1:0]        sized, placed;
  logic [LANES-1:0]     sbase;

  always_comb begin
    misal = (req_size == SZ_HALF && req_addr[0]) ||
            (req_size == SZ_WORD && req_addr[1:0] != 2'b00) ||
            (req_size == 2'b11);
    lane = req_addr[LANE_BITS-1:0];
    if (mode == MD_WIBE) begin
      if (req_size == SZ_BYTE)      lane = lane ^ 2'b11;
      else if (req_size == SZ_HALF) lane = lane ^ 2'b10;
    end
    swap = (mode == MD_BIBE);
    case (req_size)
      SZ_BYTE: begin
        sized = {{(DW-8){1'b0}}, req_wdata[7:0]};
        sbase = 4'b0001;
      end
      SZ_HALF: begin
        sized = swap ? {{(DW-16){1'b0}}, req_wdata[7:0], req_wdata[15:8]}
                     : {{(DW-16){1'b0}}, req_wdata[15:0]};
        sbase = 4'b0011;
      end
      default: begin
        sized = swap ? rev_bytes(req_wdata) : req_wdata;
        sbase = 4'b1111;
      end
    endcase
    placed   = sized << {lane, 3'b000};
    rd_issue = req_valid && !req_write && !misal;
    rd_lane  = lane;
    rd_swap  = swap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid   <= 1'b0;
      mem_write   <= 1'b0;
      mem_addr    <= '0;
      mem_strb    <= '0;
      mem_wdata   <= '0;
      align_fault <= 1'b0;
    end else begin
      mem_valid   <= req_valid && !misal;
      align_fault <= req_valid && misal;
      mem_write   <= req_write;
      mem_addr    <= {req_addr[AW-1:LANE_BITS], lane};
      mem_strb    <= sbase << lane;
      mem_wdata   <= req_write ? placed : '0;
    end
  end

  // R8
  fault_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> !mem_valid);

  // R7
  strobe_shape_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ($countones(mem_strb) == 1 || $countones(mem_strb) == 2 ||
                   $countones(mem_strb) == 4));

  // R4
  word_addr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == SZ_WORD && req_addr[1:0] == 2'b00) |=>
      (mem_valid && mem_addr == $past(req_addr)));
endmodule

// File: rtl/load_extract.sv
module load_extract
  import lane_steer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_issue,
  input  logic [LANE_BITS-1:0] rd_lane,
  input  logic [1:0]           rd_size,
  input  logic                 rd_signed,
  input  logic                 rd_swap,
  input  logic                 mem_rvalid,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 ld_valid,
  output logic [DW-1:0]        ld_data
);
  logic [LANE_BITS-1:0] lane_q;
  logic [1:0]           size_q;
  logic                 sgn_q, swap_q;
  logic [7:0]           bsel;
  logic [15:0]          hsel, hord;
  logic [DW-1:0]        res;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= '0;
      size_q <= SZ_WORD;
      sgn_q  <= 1'b0;
      swap_q <= 1'b0;
    end else if (rd_issue) begin
      lane_q <= rd_lane;
      size_q <= rd_size;
      sgn_q  <= rd_signed;
      swap_q <= rd_swap;
    end
  end

  always_comb begin
    bsel = mem_rdata[{lane_q, 3'b000} +: 8];
    hsel = mem_rdata[{lane_q[1], 4'b0000} +: 16];
    hord = swap_q ? {hsel[7:0], hsel[15:8]} : hsel;
    case (size_q)
      SZ_BYTE: res = {{(DW-8){sgn_q & bsel[7]}}, bsel};
      SZ_HALF: res = {{(DW-16){sgn_q & hord[15]}}, hord};
      default: res = swap_q ? rev_bytes(mem_rdata) : mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= mem_rvalid;
      if (mem_rvalid) ld_data <= res;
    end
  end

  // R9
  ld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |=> ld_valid);

  // R9
  ld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_rvalid |=> !ld_valid);
endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_u,
  input  logic          cfg_b,
  input  logic          cfg_ee,
  input  logic          exc_entry,
  input  logic          e_wr_en,
  input  logic          e_wr_val,
  output logic          e_bit,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic          req_signed,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_strb,
  output logic [31:0]   mem_wdata,
  output logic          align_fault,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          ld_valid,
  output logic [31:0]   ld_data,
  input  logic          if_valid,
  input  logic [31:0]   if_rdata,
  output logic          if_ivalid,
  output logic [31:0]   if_instr
);
  dmode_e               mode;
  logic                 rd_issue, rd_swap;
  logic [LANE_BITS-1:0] rd_lane;

  endian_mode_ctl u_mode (
    .clk(clk), .rst(rst), .cfg_u(cfg_u), .cfg_b(cfg_b), .cfg_ee(cfg_ee),
    .exc_entry(exc_entry), .e_wr_en(e_wr_en), .e_wr_val(e_wr_val),
    .e_q(e_bit), .mode(mode)
  );

  access_map #(.AW(AW)) u_map (
    .clk(clk), .rst(rst), .mode(mode),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_strb(mem_strb), .mem_wdata(mem_wdata), .align_fault(align_fault),
    .rd_issue(rd_issue), .rd_lane(rd_lane), .rd_swap(rd_swap)
  );

  load_extract u_load (
    .clk(clk), .rst(rst), .rd_issue(rd_issue), .rd_lane(rd_lane),
    .rd_size(req_size), .rd_signed(req_signed), .rd_swap(rd_swap),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      if_ivalid <= 1'b0;
      if_instr  <= '0;
    end else begin
      if_ivalid <= if_valid;
      if (if_valid) if_instr <= if_rdata;
    end
  end

  // R10
  fetch_pass_chk: assert property (@(posedge clk) disable iff (rst)
    if_valid |=> (if_ivalid && if_instr == $past(if_rdata)));
endmodule

// File: tb/endian_lane_steer_tb.sv
module endian_lane_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] WD   = 32'hA1B2_C3D4;
  localparam logic [31:0] RD   = 32'h1122_83F4;

  typedef struct packed {
    logic u, b, e;
    logic [1:0] sz;
    logic sg;
    logic [1:0] alo;
    logic [1:0] xalo;
    logic [3:0] xstrb;
    logic [31:0] xwd;
    logic [31:0] xld;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,2'd0,1'b1,2'd1,2'd1,4'b0010,32'h0000_D400,32'hFFFF_FF83},
    '{1'b0,1'b0,1'b0,2'd1,1'b0,2'd2,2'd2,4'b1100,32'hC3D4_0000,32'h0000_1122},
    '{1'b0,1'b0,1'b0,2'd2,1'b0,2'd0,2'd0,4'b1111,32'hA1B2_C3D4,32'h1122_83F4},
    '{1'b0,1'b1,1'b0,2'd0,1'b0,2'd0,2'd3,4'b1000,32'hD400_0000,32'h0000_0011},
    '{1'b0,1'b1,1'b0,2'd0,1'b1,2'd2,2'd1,4'b0010,32'h0000_D400,32'hFFFF_FF83},
    '{1'b0,1'b1,1'b0,2'd1,1'b1,2'd2,2'd0,4'b0011,32'h0000_C3D4,32'hFFFF_83F4},
    '{1'b0,1'b1,1'b1,2'd2,1'b0,2'd0,2'd0,4'b1111,32'hA1B2_C3D4,32'h1122_83F4},
    '{1'b1,1'b0,1'b1,2'd0,1'b1,2'd3,2'd3,4'b1000,32'hD400_0000,32'h0000_0011},
    '{1'b1,1'b0,1'b1,2'd1,1'b1,2'd0,2'd0,4'b0011,32'h0000_D4C3,32'hFFFF_F483},
    '{1'b1,1'b0,1'b1,2'd1,1'b0,2'd2,2'd2,4'b1100,32'hD4C3_0000,32'h0000_2211},
    '{1'b1,1'b0,1'b1,2'd2,1'b0,2'd0,2'd0,4'b1111,32'hD4C3_B2A1,32'hF483_2211},
    '{1'b1,1'b1,1'b1,2'd2,1'b0,2'd0,2'd0,4'b1111,32'hD4C3_B2A1,32'hF483_2211},
    '{1'b1,1'b1,1'b0,2'd1,1'b1,2'd2,2'd2,4'b1100,32'hC3D4_0000,32'h0000_1122},
    '{1'b1,1'b0,1'b0,2'd0,1'b1,2'd0,2'd0,4'b0001,32'h0000_00D4,32'hFFFF_FFF4}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_u = 0, cfg_b = 0, cfg_ee = 1, exc_entry = 0, e_wr_en = 0, e_wr_val = 0;
  logic e_bit;
  logic req_valid = 0, req_write = 0, req_signed = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic mem_valid, mem_write, align_fault;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_strb;
  logic mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;
  logic ld_valid;
  logic [31:0] ld_data;
  logic if_valid = 0;
  logic [31:0] if_rdata = 0;
  logic if_ivalid;
  logic [31:0] if_instr;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  endian_lane_steer #(.AW(32)) u_dut (
    .clk(clk), .rst(rst), .cfg_u(cfg_u), .cfg_b(cfg_b), .cfg_ee(cfg_ee),
    .exc_entry(exc_entry), .e_wr_en(e_wr_en), .e_wr_val(e_wr_val), .e_bit(e_bit),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_strb(mem_strb), .mem_wdata(mem_wdata), .align_fault(align_fault),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .if_valid(if_valid), .if_rdata(if_rdata), .if_ivalid(if_ivalid), .if_instr(if_instr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic set_e(input logic v);
    e_wr_en = 1; e_wr_val = v;
    @(negedge clk);
    e_wr_en = 0;
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic sg,
                        input logic [31:0] a, input logic [31:0] d);
    req_valid = 1; req_write = wr; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic respond(input logic [31:0] d);
    mem_rvalid = 1; mem_rdata = d;
    @(negedge clk);
    mem_rvalid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, e_bit taken from cfg_ee
    chk("R1 e_bit", {31'd0, e_bit}, 32'd1);
    chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
    chk("R1 align_fault", {31'd0, align_fault}, 32'd0);
    chk("R1 ld_valid", {31'd0, ld_valid}, 32'd0);
    chk("R1 if_ivalid", {31'd0, if_ivalid}, 32'd0);
    // R1: reset configuration is little-endian
    access(1, 2'd0, 0, BASE | 32'd2, WD);
    chk("R1 le strb", {28'd0, mem_strb}, 32'h4);

    for (int i = 0; i < NV; i++) begin
      string tag;
      vec_t v;
      v = VECS[i];
      tag = !v.u ? (v.b ? "R4" : "R3") : (v.e ? "R5" : "R6");
      cfg_u = v.u; cfg_b = v.b;
      set_e(v.e);
      access(1, v.sz, v.sg, BASE | {30'd0, v.alo}, WD);
      chk({tag, " st valid"}, {30'd0, mem_valid, mem_write}, 32'd3);
      chk({tag, " st addr"}, mem_addr, BASE | {30'd0, v.xalo});
      chk("R7 st strb", {28'd0, mem_strb}, {28'd0, v.xstrb});
      chk({tag, " st data"}, mem_wdata, v.xwd);
      access(0, v.sz, v.sg, BASE | {30'd0, v.alo}, 32'd0);
      chk({tag, " rd addr"}, mem_addr, BASE | {30'd0, v.xalo});
      chk("R7 rd strb", {28'd0, mem_strb}, {28'd0, v.xstrb});
      chk("R9 rd valid", {30'd0, mem_valid, mem_write}, 32'd2);
      respond(RD);
      chk("R9 ld valid", {31'd0, ld_valid}, 32'd1);
      chk({"R9 ", tag, " ld data"}, ld_data, v.xld);
    end

    // R2: exception entry beats a same-cycle software write
    cfg_ee = 0;
    exc_entry = 1; e_wr_en = 1; e_wr_val = 1;
    @(negedge clk);
    exc_entry = 0; e_wr_en = 0;
    chk("R2 exc priority", {31'd0, e_bit}, 32'd0);
    // R2 + R6: store in cycle of E change uses old (little-endian) value
    cfg_u = 1; cfg_b = 0;
    e_wr_en = 1; e_wr_val = 1;
    access(1, 2'd1, 0, BASE, WD);
    e_wr_en = 0;
    chk("R6 old E store", mem_wdata, 32'h0000_C3D4);
    chk("R2 sw write", {31'd0, e_bit}, 32'd1);
    access(1, 2'd1, 0, BASE, WD);
    chk("R5 new E store", mem_wdata, 32'h0000_D4C3);

    // R8: misaligned and invalid requests
    access(1, 2'd1, 0, BASE | 32'd1, WD);
    chk("R8 half fault", {30'd0, align_fault, mem_valid}, 32'd2);
    access(0, 2'd2, 0, BASE | 32'd2, 32'd0);
    chk("R8 word fault", {30'd0, align_fault, mem_valid}, 32'd2);
    access(1, 2'd3, 0, BASE, WD);
    chk("R8 size3 fault", {30'd0, align_fault, mem_valid}, 32'd2);
    @(negedge clk);
    chk("R8 fault one cycle", {31'd0, align_fault}, 32'd0);

    // R10: fetch word untouched in byte-invariant and word-invariant modes
    if_valid = 1; if_rdata = 32'hDEAD_BEEF;
    @(negedge clk);
    if_valid = 0;
    chk("R10 fetch bi valid", {31'd0, if_ivalid}, 32'd1);
    chk("R10 fetch bi", if_instr, 32'hDEAD_BEEF);
    cfg_u = 0; cfg_b = 1;
    if_valid = 1; if_rdata = 32'h0102_0304;
    @(negedge clk);
    if_valid = 0;
    chk("R10 fetch wi", if_instr, 32'h0102_0304);

    // R2: exception entry with cfg_ee=1 reloads E
    cfg_ee = 1; cfg_u = 1; cfg_b = 0;
    set_e(0);
    exc_entry = 1;
    @(negedge clk);
    exc_entry = 0;
    chk("R2 exc reload", {31'd0, e_bit}, 32'd1);

    finish_run();
  end
endmodule